// File: doc/BRIEF.md
# Clock-Chip Host Register Port with Interrupt Status

This block is the host side of a real-time clock chip. A host reaches the whole 128-byte register space through two byte addresses. Writing the even address selects a register index. Reading or writing the odd address then reaches the selected register. Most of the space is plain byte storage. Indexes 10 to 13 hold the control and status registers A, B, C and D. These keep their fixed offsets because host software finds them there, and they have access side effects. Counting time is done by a neighbouring block, which only supplies strobes.

Status register C gathers three event strobes: periodic tick, alarm match and update ended. Control register B enables each of them. The block drives one active-high interrupt line, and the line follows the summary bit C[7]. Reading C hands the flags to the host and clears them. Writing B can raise or drop the interrupt at once, depending on which flags are already pending. The low fields of A and the whole of B are driven out to the rest of the chip. Data read from the odd address appears on `rdata` one clock after the read strobe.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (addr0=0) loads wdata[6:0] into the index; bit 7 is discarded. A write to the odd address (addr0=1) stores wdata in the indexed byte. Every index except 10 to 13 reads back the stored byte, and these bytes reset to 0x00.
- R2: A read from the even address returns 0xFF. Every read result appears on rdata at the clock edge that samples rd_en, and rdata holds its value when no read is made.
- R3: Writes to index 12 (C) and index 13 (D) change nothing. Index 13 always reads 0x80.
- R4: A read of index 12 returns C as it stood, then clears C to 0x00 and lowers irq. An event strobe in the same cycle as that read is kept: its flag is set afterwards, and irq rises if the flag is enabled.
- R5: The event strobes set flags in C: ev_update sets C[4], ev_alarm sets C[5] and ev_periodic sets C[6]. C[7] and irq are set only when a flag that was clear becomes set while its enable is set. B[4] enables C[4], B[5] enables C[5] and B[6] enables C[6]. An enabled flag that is already set does not raise irq again.
- R6: On a write to index 11 (B), C[7] and irq become 1 if a new enable in B[6:4] matches a set flag in C[6:4]. Otherwise both become 0.
- R7: A write to B with bit 7 (freeze) set stores B[4] as 0 and clears A[7].
- R8: A write to index 10 (A) changes only A[6:0]. A[7] is a busy bit: busy_set sets it, ev_update clears it, and a clear wins over a set.
- R9: After rst_n the registers hold A=0x26, B=0x02, C=0x00, D=0x80, and irq=0.
- R10: soft_rst clears B[6], B[5] and B[3], clears C[7:4] and lowers irq. The other bits of B and all of A are kept. soft_rst takes priority over events in the same cycle.
- R11: If rd_en and wr_en are high in the same cycle, only the write acts. rdata holds, and C is not cleared.
- R12: rate_sel is A[3:0], div_sel is A[6:4] and mode_bits is B, all visible in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the power-up values |
| soft_rst | input | 1 | Synchronous system reset of the enables and flags |
| addr0 | input | 1 | Port select: 0 = index, 1 = data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ev_periodic | input | 1 | Periodic tick strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_update | input | 1 | Update-ended strobe |
| busy_set | input | 1 | Sets the busy bit A[7] |
| irq | output | 1 | Interrupt, active high |
| rate_sel | output | 4 | A[3:0] |
| div_sel | output | 3 | A[6:4] |
| mode_bits | output | 8 | Register B |

## Verification
A wrong flag, enable or summary bit shows up on irq in the very next cycle. It also shows up the next time the host reads C. The bench compares irq and the control fields after every clock, and compares rdata after every read. A stale index or a lost write therefore shows up at the first read that touches that byte. The cases that matter most are cycles where two things meet: a read of C alongside an event, a write to B alongside an event or a soft reset, and a read alongside a write.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
   // Control register offsets (host software decodes these)
   localparam int unsigned IDX_REG_A = 10;
   localparam int unsigned IDX_REG_B = 11;
   localparam int unsigned IDX_REG_C = 12;
   localparam int unsigned IDX_REG_D = 13;

   // Register B bit positions
   localparam int unsigned B_FREEZE = 7;
   localparam int unsigned B_PER_EN = 6;
   localparam int unsigned B_ALM_EN = 5;
   localparam int unsigned B_UPD_EN = 4;
   localparam int unsigned B_WAVE_EN = 3;

   // Register C: summary bit and flag field
   localparam int unsigned C_SUMMARY = 7;
   localparam int unsigned FLAG_LO = 4;
   localparam int unsigned N_EVENTS = 3;

   typedef logic [N_EVENTS-1:0] evt_t;  // [2]=periodic [1]=alarm [0]=update
endpackage

// File: rtl/rp_index.sv
module rp_index #(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din;
   end
endmodule

// File: rtl/rp_store.sv
module rp_store #(
   parameter int unsigned IDX_W = 7,
   parameter int unsigned DW    = 8,
   parameter int unsigned SKIP_LO = 10,
   parameter int unsigned SKIP_HI = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DEPTH*DW-1:0] flat;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      if (gi >= SKIP_LO && gi <= SKIP_HI) begin : g_hole
         // control registers live elsewhere
         assign flat[gi*DW +: DW] = '0;
      end else begin : g_byte
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && idx == IDX_W'(gi))
               q <= din;
         end
         assign flat[gi*DW +: DW] = q;
      end
   end

   assign dout = flat[int'(idx)*DW +: DW];
endmodule

// File: rtl/rp_ctrl.sv
module rp_ctrl
   import rtc_regport_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter logic [7:0]  RST_A = 8'h26,
   parameter logic [7:0]  RST_B = 8'h02
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic [DW-1:0] din,
   input  logic          busy_set,
   input  logic          upd_done,
   output logic [DW-1:0] a_q,
   output logic [DW-1:0] b_q,
   output logic [DW-1:0] b_new
);
   localparam logic [DW-1:0] SOFT_B_MASK =
      DW'((1 << B_PER_EN) | (1 << B_ALM_EN) | (1 << B_WAVE_EN));

   logic freeze_wr;

   always_comb begin
      b_new = din;
      if (din[B_FREEZE]) b_new[B_UPD_EN] = 1'b0;
   end

   assign freeze_wr = wr_b && din[B_FREEZE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= DW'(RST_A);
         b_q <= DW'(RST_B);
      end else begin
         if (wr_a) a_q[DW-2:0] <= din[DW-2:0];
         if (upd_done || freeze_wr)  a_q[DW-1] <= 1'b0;
         else if (busy_set)          a_q[DW-1] <= 1'b1;
         if (soft_rst)  b_q <= (wr_b ? b_new : b_q) & ~SOFT_B_MASK;
         else if (wr_b) b_q <= b_new;
      end
   end

   // R7: a freeze write leaves update enable and busy cleared
   a_r7_freeze_drops_upd: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_wr |=> (!b_q[B_UPD_EN] && !a_q[DW-1]));

   // R8: a plain write to A keeps the busy bit
   a_r8_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && !busy_set && !upd_done && !wr_b) |=> (a_q[DW-1] == $past(a_q[DW-1])));

   // R10: system reset leaves the three enables clear
   a_r10_enables_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ((b_q & SOFT_B_MASK) == '0));
endmodule

// File: rtl/rp_status.sv
module rp_status
   import rtc_regport_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  evt_t          ev,
   input  evt_t          en_cur,
   input  logic          wr_b,
   input  evt_t          en_new,
   input  logic          rd_c,
   output logic [DW-1:0] c_q,
   output logic          irq
);
   evt_t flags_q, flags_base, fresh, flags_n;
   logic sum_q, sum_base, sum_n;

   always_comb begin
      flags_base = rd_c ? '0 : flags_q;
      sum_base   = rd_c ? 1'b0 : sum_q;
      fresh      = ev & ~flags_base;
      flags_n    = flags_base | ev;
      if (wr_b) sum_n = |(en_new & flags_n);
      else      sum_n = sum_base | (|(en_cur & fresh));
      if (soft_rst) begin
         flags_n = '0;
         sum_n   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         sum_q   <= 1'b0;
      end else begin
         flags_q <= flags_n;
         sum_q   <= sum_n;
      end
   end

   always_comb begin
      c_q = '0;
      c_q[C_SUMMARY] = sum_q;
      c_q[FLAG_LO +: N_EVENTS] = flags_q;
   end
   assign irq = sum_q;

   // R4: reading C with no event pending empties it
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c && ev == '0 && !soft_rst) |=> (c_q == '0 && !irq));

   // R5: an enabled event raises the line
   a_r5_enabled_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_b && !soft_rst && (ev & en_cur) != '0) |=> irq);

   // R6: after a B write the line matches the overlap of enables and flags
   a_r6_b_write_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && !soft_rst && ev == '0 && !rd_c) |=> (irq == |(($past(en_new)) & $past(flags_q))));

   // R10: system reset empties the status register
   a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (c_q == '0 && !irq));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
   import rtc_regport_pkg::*;
#(
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned DW     = 8,
   parameter int unsigned RD_LAT = 1,
   parameter logic [7:0]  RST_A  = 8'h26,
   parameter logic [7:0]  RST_B  = 8'h02,
   parameter logic [7:0]  RST_D  = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       addr0,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       ev_periodic,
   input  logic       ev_alarm,
   input  logic       ev_update,
   input  logic       busy_set,
   output logic       irq,
   output logic [3:0] rate_sel,
   output logic [2:0] div_sel,
   output logic [7:0] mode_bits
);
   localparam logic [DW-1:0] IDLE_BYTE = '1;

   // elaboration checks
   if (DW != 8) begin : g_bad_dw
      $error("rtc_regport: DW must be 8");
   end
   if ((1 << IDX_W) <= IDX_REG_D) begin : g_bad_idx
      $error("rtc_regport: IDX_W too small for control registers");
   end
   if (RD_LAT > 1) begin : g_bad_lat
      $error("rtc_regport: RD_LAT must be 0 or 1");
   end

   logic [IDX_W-1:0] idx;
   logic wr_even, wr_odd, rd_odd, rd_any;
   logic hit_a, hit_b, hit_c, hit_d, hit_ctl;
   logic [DW-1:0] store_q, a_q, b_q, b_new, c_q, rd_mux;
   evt_t ev;

   assign wr_even = wr_en && !addr0;
   assign wr_odd  = wr_en && addr0;
   assign rd_any  = rd_en && !wr_en;
   assign rd_odd  = rd_any && addr0;

   assign hit_a   = (idx == IDX_W'(IDX_REG_A));
   assign hit_b   = (idx == IDX_W'(IDX_REG_B));
   assign hit_c   = (idx == IDX_W'(IDX_REG_C));
   assign hit_d   = (idx == IDX_W'(IDX_REG_D));
   assign hit_ctl = hit_a || hit_b || hit_c || hit_d;

   assign ev = {ev_periodic, ev_alarm, ev_update};

   rp_index #(.IDX_W(IDX_W)) u_index (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wr_even),
      .din  (wdata[IDX_W-1:0]),
      .idx  (idx)
   );

   rp_store #(.IDX_W(IDX_W), .DW(DW), .SKIP_LO(IDX_REG_A), .SKIP_HI(IDX_REG_D)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_odd && !hit_ctl),
      .idx  (idx),
      .din  (wdata),
      .dout (store_q)
   );

   rp_ctrl #(.DW(DW), .RST_A(RST_A), .RST_B(RST_B)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .wr_a    (wr_odd && hit_a),
      .wr_b    (wr_odd && hit_b),
      .din     (wdata),
      .busy_set(busy_set),
      .upd_done(ev_update),
      .a_q     (a_q),
      .b_q     (b_q),
      .b_new   (b_new)
   );

   rp_status #(.DW(DW)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .ev      (ev),
      .en_cur  (b_q[FLAG_LO +: N_EVENTS]),
      .wr_b    (wr_odd && hit_b),
      .en_new  (b_new[FLAG_LO +: N_EVENTS]),
      .rd_c    (rd_odd && hit_c),
      .c_q     (c_q),
      .irq     (irq)
   );

   always_comb begin
      if (!addr0)      rd_mux = IDLE_BYTE;
      else if (hit_a)  rd_mux = a_q;
      else if (hit_b)  rd_mux = b_q;
      else if (hit_c)  rd_mux = c_q;
      else if (hit_d)  rd_mux = DW'(RST_D);
      else             rd_mux = store_q;
   end

   if (RD_LAT == 1) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata <= '0;
         else if (rd_any) rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rdata = rd_mux;
   end

   assign rate_sel  = a_q[3:0];
   assign div_sel   = a_q[6:4];
   assign mode_bits = b_q;

   // R3: writing C leaves it unchanged when nothing else acts on it
   a_r3_c_unwritable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_odd && hit_c && ev == '0 && !soft_rst) |=> $stable(c_q));

   // R11: a read beside a write leaves rdata alone
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |=> $stable(rdata));
endmodule

// File: tb/rtc_regport_test.sv
module rtc_regport_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0, addr0 = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0, busy_set = 1'b0;
   logic irq;
   logic [3:0] rate_sel;
   logic [2:0] div_sel;
   logic [7:0] mode_bits;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // model state
   logic [7:0] m_mem [128];
   logic [6:0] m_idx;
   logic [7:0] m_a, m_b, m_c, m_rd;

   always #4 clk = ~clk;

   rtc_regport uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr0(addr0),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
      .busy_set(busy_set), .irq(irq), .rate_sel(rate_sel), .div_sel(div_sel),
      .mode_bits(mode_bits)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [6:0] i);
      case (i)
         7'd10:   return m_a;
         7'd11:   return m_b;
         7'd12:   return m_c;
         7'd13:   return 8'h80;
         default: return m_mem[i];
      endcase
   endfunction

   // One clock: drive at a falling edge, check at the next falling edge.
   task automatic step(input logic wr, input logic rd, input logic a0, input logic [7:0] wd,
                       input logic [2:0] ev, input logic busy, input logic srst,
                       input string tag);
      logic rd_eff, bw;
      logic [7:0] nb;
      logic [2:0] flags, fresh;
      logic sum;
      wr_en = wr; rd_en = rd; addr0 = a0; wdata = wd;
      ev_periodic = ev[2]; ev_alarm = ev[1]; ev_update = ev[0];
      busy_set = busy; soft_rst = srst;
      // expected next state from the requirements
      rd_eff = rd && !wr;
      if (rd_eff) m_rd = a0 ? model_read(m_idx) : 8'hFF;
      bw = wr && a0 && m_idx == 7'd11;
      nb = m_b;
      if (bw) begin
         nb = wd;
         if (wd[7]) nb[4] = 1'b0;
      end
      flags = m_c[6:4]; sum = m_c[7];
      if (rd_eff && a0 && m_idx == 7'd12) begin flags = '0; sum = 1'b0; end
      fresh = ev & ~flags;
      flags = flags | ev;
      if (bw) sum = |(nb[6:4] & flags);
      else    sum = sum | (|(m_b[6:4] & fresh));
      if (wr && a0 && m_idx == 7'd10) m_a[6:0] = wd[6:0];
      if (ev[0] || (bw && wd[7])) m_a[7] = 1'b0;
      else if (busy)              m_a[7] = 1'b1;
      if (wr && a0 && (m_idx < 7'd10 || m_idx > 7'd13)) m_mem[m_idx] = wd;
      if (wr && !a0) m_idx = wd[6:0];
      if (srst) begin
         nb = nb & ~8'h68;
         flags = '0; sum = 1'b0;
      end
      m_b = nb;
      m_c = {sum, flags, 4'b0000};
      @(negedge clk);
      check8({tag, " irq"}, {7'b0, irq}, {7'b0, m_c[7]});
      check8({tag, " rdata"}, rdata, m_rd);
      check8("R12 fields", {1'b0, div_sel, rate_sel}, {1'b0, m_a[6:0]});
      check8("R12 mode", mode_bits, m_b);
   endtask

   task automatic set_idx(input logic [7:0] i, input string tag);
      step(1, 0, 0, i, 3'b000, 0, 0, tag);
   endtask
   task automatic wr_reg(input logic [7:0] i, input logic [7:0] v, input string tag);
      set_idx(i, tag);
      step(1, 0, 1, v, 3'b000, 0, 0, tag);
   endtask
   task automatic rd_reg(input logic [7:0] i, input logic [7:0] exp, input string tag);
      set_idx(i, tag);
      step(0, 1, 1, 8'h00, 3'b000, 0, 0, tag);
      check8({tag, " direct"}, rdata, exp);
   endtask
   task automatic idle(input logic [2:0] ev, input logic busy, input logic srst, input string tag);
      step(0, 0, 0, 8'h00, ev, busy, srst, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2718));
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      m_idx = '0; m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_rd = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check8("R9 irq at reset", {7'b0, irq}, 8'h00);
      rd_reg(8'd10, 8'h26, "R9 A");
      rd_reg(8'd11, 8'h02, "R9 B");
      rd_reg(8'd12, 8'h00, "R9 C");
      rd_reg(8'd13, 8'h80, "R9 D");
      // R2 even read
      step(0, 1, 0, 8'h00, 3'b000, 0, 0, "R2 even");
      check8("R2 even direct", rdata, 8'hFF);
      // R1 storage and index bit 7 dropped
      wr_reg(8'hA0, 8'h5A, "R1 store");
      rd_reg(8'h20, 8'h5A, "R1 readback");
      rd_reg(8'h00, 8'h00, "R1 untouched");
      // R3 C and D ignore writes
      wr_reg(8'd12, 8'hFF, "R3 C wr");
      wr_reg(8'd13, 8'h00, "R3 D wr");
      rd_reg(8'd12, 8'h00, "R3 C");
      rd_reg(8'd13, 8'h80, "R3 D");
      // R5 enabled periodic event
      wr_reg(8'd11, 8'h42, "R5 en");
      idle(3'b100, 0, 0, "R5 periodic");
      check8("R5 irq direct", {7'b0, irq}, 8'h01);
      // R4 read C clears
      rd_reg(8'd12, 8'hC0, "R4 read C");
      check8("R4 irq low", {7'b0, irq}, 8'h00);
      // R5 disabled alarm event, R6 enable on pending flag
      idle(3'b010, 0, 0, "R5 alarm masked");
      check8("R5 masked irq", {7'b0, irq}, 8'h00);
      wr_reg(8'd11, 8'h62, "R6 enable pending");
      check8("R6 irq raised", {7'b0, irq}, 8'h01);
      wr_reg(8'd11, 8'h42, "R6 disable pending");
      check8("R6 irq dropped", {7'b0, irq}, 8'h00);
      // R5 flag already set does not re-raise
      idle(3'b010, 0, 0, "R5 no reraise");
      check8("R5 no reraise direct", {7'b0, irq}, 8'h00);
      // R4 read C alongside an event keeps the event
      wr_reg(8'd11, 8'h12, "R4 upd en");
      set_idx(8'd12, "R4 idx");
      step(0, 1, 1, 8'h00, 3'b001, 0, 0, "R4 read+event");
      check8("R4 read+event old", rdata, 8'h20);
      check8("R4 event kept irq", {7'b0, irq}, 8'h01);
      rd_reg(8'd12, 8'h90, "R4 event kept");
      // R8 busy bit
      wr_reg(8'd10, 8'hFF, "R8 A write");
      rd_reg(8'd10, 8'h7F, "R8 A low bits");
      idle(3'b000, 1, 0, "R8 busy set");
      wr_reg(8'd10, 8'h00, "R8 A keep busy");
      rd_reg(8'd10, 8'h80, "R8 busy kept");
      idle(3'b001, 1, 0, "R8 clear wins");
      rd_reg(8'd10, 8'h00, "R8 clear wins");
      // R7 freeze
      idle(3'b000, 1, 0, "R7 busy");
      wr_reg(8'd11, 8'h9A, "R7 freeze");
      rd_reg(8'd11, 8'h8A, "R7 upd en dropped");
      rd_reg(8'd10, 8'h00, "R7 busy cleared");
      // R10 system reset
      wr_reg(8'd11, 8'h7F, "R10 enables");
      idle(3'b111, 0, 0, "R10 events");
      idle(3'b000, 0, 1, "R10 soft reset");
      check8("R10 irq low", {7'b0, irq}, 8'h00);
      rd_reg(8'd11, 8'h17, "R10 B masked");
      rd_reg(8'd12, 8'h00, "R10 C clear");
      // R11 read beside write
      wr_reg(8'd11, 8'h10, "R11 setup");
      idle(3'b001, 0, 0, "R11 flag");
      set_idx(8'd12, "R11 idx");
      step(1, 1, 1, 8'h00, 3'b000, 0, 0, "R11 rd+wr");
      rd_reg(8'd12, 8'h90, "R11 C kept");

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         int op;
         logic [7:0] wd;
         logic [2:0] ev;
         op = $urandom_range(0, 9);
         ev = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
         case ($urandom_range(0, 5))
            0: wd = 8'd10;
            1: wd = 8'd11;
            2: wd = 8'd12;
            3: wd = 8'd13;
            4: wd = 8'h20 + 8'($urandom_range(0, 3));
            default: wd = 8'($urandom_range(0, 255));
         endcase
         case (op)
            0, 1: step(1, 0, 0, wd, ev, $urandom_range(0, 7) == 0, 0, "R1 rnd index");
            2, 3: step(1, 0, 1, 8'($urandom_range(0, 255)), ev, $urandom_range(0, 7) == 0, 0, "R6 rnd write");
            4, 5: step(0, 1, 1, 8'h00, ev, $urandom_range(0, 7) == 0, 0, "R4 rnd read");
            6:    step(0, 1, 0, 8'h00, ev, 0, 0, "R2 rnd even");
            7:    step(0, 0, 0, 8'h00, ev, $urandom_range(0, 7) == 0, 0, "R5 rnd idle");
            8:    step(1, 1, 1, 8'($urandom_range(0, 255)), ev, 0, 0, "R11 rnd both");
            default: step(0, 0, 0, 8'h00, ev, 0, $urandom_range(0, 9) == 0, "R10 rnd reset");
         endcase
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule